// File: doc/BRIEF.md
# Load/Store Address and Legality Unit

This unit sits between instruction decode and the memory pipeline for fixed-point loads and stores. For each accepted operation it forms the effective address from an optional base register and a displacement. The displacement is either a sign-extended immediate or the value of a second register. The unit issues one memory request carrying the access size and direction. For update-form accesses it also asks for the address to be written back into the base register.

The unit also screens out illegal register combinations. If an update form names register zero as its base, the operation is flagged invalid. The same happens when an update-form load or a quadword load would overwrite its own base. A flagged operation raises neither a memory request nor a writeback. For quadword transfers the unit names which register of the target pair takes the low doubleword and which takes the high one. The choice depends on the endian mode and on whether the operation came in prefixed form.

Every result is registered, so it appears one cycle after the input handshake. The input side accepts a new operation on every cycle outside reset.

Top module: `ldst_agu`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, mem_req, wb_en and invalid are all low.
- R2: in_ready is high whenever rst is low. An operation presented with in_valid and in_ready high at a clock edge shows on the outputs with out_valid high for exactly the next cycle. Without such a handshake, out_valid is low in the next cycle.
- R3: The displacement is rb_val when disp_sel is 1, and the IMM_W-bit imm_val sign-extended to 64 bits when disp_sel is 0. mem_addr is the displacement alone when ra_idx is 0. Otherwise it is base_val plus the displacement, modulo 2^64.
- R4: A non-quad update access (is_update=1) whose ra_idx is 0 is flagged invalid.
- R5: A non-quad update load whose ra_idx equals rt_idx is flagged invalid. The same combination on a store is legal.
- R6: A legal non-quad update access raises wb_en with wb_idx equal to ra_idx. The value to write back is the mem_addr shown in the same cycle.
- R7: When invalid is high, mem_req and wb_en are low in that cycle. A legal accepted operation raises mem_req.
- R8: A quadword load (is_quad=1, is_store=0) whose ra_idx equals rt_idx is flagged invalid. A quadword access never raises wb_en, whatever is_update says.
- R9: For a quadword access, quad_lo_idx is rt_idx and quad_hi_idx is rt_idx+1 (modulo 32) when le_mode and prefixed are both 1. In every other case quad_lo_idx is rt_idx+1 and quad_hi_idx is rt_idx.
- R10: mem_write equals is_store. mem_size is 3'd7 for a quadword access. Otherwise mem_size equals size_code, with 0 byte, 1 halfword zero-extended, 2 halfword sign-extended, 3 word zero-extended, 4 word sign-extended and 5 doubleword.
- R11: A non-quad access with size_code 6 or 7 is flagged invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| rt_idx | input | 5 | Target (load) or source (store) register index |
| ra_idx | input | 5 | Base register index, 0 means no base |
| base_val | input | 64 | Value of the base register |
| rb_val | input | 64 | Value of the index register |
| imm_val | input | IMM_W | Signed immediate displacement |
| disp_sel | input | 1 | 1 selects rb_val, 0 selects imm_val |
| is_update | input | 1 | Update form, base gets the address |
| is_store | input | 1 | 1 store, 0 load |
| size_code | input | 3 | Access size and extension code |
| is_quad | input | 1 | 128-bit pair access |
| le_mode | input | 1 | Little-endian mode |
| prefixed | input | 1 | Operation came in prefixed form |
| out_valid | output | 1 | Registered result present |
| mem_req | output | 1 | Legal memory request strobe |
| mem_write | output | 1 | Request is a write |
| mem_size | output | 3 | Access size code |
| mem_addr | output | 64 | Effective address |
| wb_en | output | 1 | Write mem_addr into the base register |
| wb_idx | output | 5 | Base register to write |
| invalid | output | 1 | Illegal form detected |
| quad_lo_idx | output | 5 | Register taking the low doubleword |
| quad_hi_idx | output | 5 | Register taking the high doubleword |

## Verification
A legality decision that is held wrong internally shows up at the ports in the very next cycle after the handshake. Either a memory request and base writeback appear for an illegal form, or the invalid flag appears on a legal one. A wrong address sum or pair order also shows in that same cycle, on mem_addr or on the pair indices. Nothing carries over between operations, so one bad operation cannot hide an error in another. Back-to-back operations, including a legal one right after an invalid one, expose any strobe that is held stale.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int XLEN   = 64;
    localparam int REG_AW = 5;

    typedef enum logic [2:0] {
        SZ_BYTE    = 3'd0,
        SZ_HALF    = 3'd1,
        SZ_HALF_SX = 3'd2,
        SZ_WORD    = 3'd3,
        SZ_WORD_SX = 3'd4,
        SZ_DWORD   = 3'd5,
        SZ_RSVD    = 3'd6,
        SZ_QUAD    = 3'd7
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0]   addr;
        acc_size_e         size;
        logic              write;
        logic              bad;
        logic              wb;
        logic [REG_AW-1:0] wb_idx;
        logic [REG_AW-1:0] lo_idx;
        logic [REG_AW-1:0] hi_idx;
    } ldst_result_t;

    function automatic logic size_is_reserved(input logic [2:0] code);
        return (code == 3'd6) || (code == 3'd7);
    endfunction

endpackage

// File: rtl/ldst_ea_calc.sv
module ldst_ea_calc #(
    parameter int XLEN   = 64,
    parameter int IMM_W  = 16,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ra_idx,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              disp_sel,
    output logic [XLEN-1:0]   ea
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] base_term;

    always_comb begin
        disp      = disp_sel ? rb_val : {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        base_term = (ra_idx == '0) ? '0 : base_val;
        ea        = base_term + disp;
    end
endmodule

// File: rtl/ldst_form_check.sv
module ldst_form_check
    import ldst_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rt_idx,
    input  logic [REG_AW-1:0] ra_idx,
    input  logic              is_update,
    input  logic              is_store,
    input  logic              is_quad,
    input  logic [2:0]        size_code,
    output logic              bad,
    output logic              wb,
    output acc_size_e         eff_size
);
    logic base_zero;
    logic self_hit;
    logic upd_bad;
    logic quad_bad;
    logic size_bad;

    always_comb begin
        base_zero = (ra_idx == '0);
        self_hit  = (ra_idx == rt_idx);
        upd_bad   = !is_quad && is_update && (base_zero || (!is_store && self_hit));
        quad_bad  = is_quad && !is_store && self_hit;
        size_bad  = !is_quad && size_is_reserved(size_code);
        bad       = upd_bad || quad_bad || size_bad;
        wb        = is_update && !is_quad && !bad;
        eff_size  = is_quad ? SZ_QUAD : acc_size_e'(size_code);
    end
endmodule

// File: rtl/ldst_pair_steer.sv
module ldst_pair_steer #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] rt_idx,
    input  logic              le_mode,
    input  logic              prefixed,
    output logic [REG_AW-1:0] lo_idx,
    output logic [REG_AW-1:0] hi_idx
);
    logic [REG_AW-1:0] rt_next;
    logic              swap;

    always_comb begin
        rt_next = rt_idx + REG_AW'(1);
        swap    = le_mode && prefixed;
        lo_idx  = swap ? rt_idx  : rt_next;
        hi_idx  = swap ? rt_next : rt_idx;
    end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [4:0]        rt_idx,
    input  logic [4:0]        ra_idx,
    input  logic [63:0]       base_val,
    input  logic [63:0]       rb_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              disp_sel,
    input  logic              is_update,
    input  logic              is_store,
    input  logic [2:0]        size_code,
    input  logic              is_quad,
    input  logic              le_mode,
    input  logic              prefixed,
    output logic              out_valid,
    output logic              mem_req,
    output logic              mem_write,
    output logic [2:0]        mem_size,
    output logic [63:0]       mem_addr,
    output logic              wb_en,
    output logic [4:0]        wb_idx,
    output logic              invalid,
    output logic [4:0]        quad_lo_idx,
    output logic [4:0]        quad_hi_idx
);
    logic [XLEN-1:0]   ea;
    logic              chk_bad;
    logic              chk_wb;
    acc_size_e         chk_size;
    logic [REG_AW-1:0] pr_lo;
    logic [REG_AW-1:0] pr_hi;
    ldst_result_t      nxt;
    ldst_result_t      res_q;
    logic              vld_q;
    logic              accept;

    ldst_ea_calc #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_AW(REG_AW)) u_ea (
        .ra_idx   (ra_idx),
        .base_val (base_val),
        .rb_val   (rb_val),
        .imm_val  (imm_val),
        .disp_sel (disp_sel),
        .ea       (ea)
    );

    ldst_form_check #(.REG_AW(REG_AW)) u_chk (
        .rt_idx    (rt_idx),
        .ra_idx    (ra_idx),
        .is_update (is_update),
        .is_store  (is_store),
        .is_quad   (is_quad),
        .size_code (size_code),
        .bad       (chk_bad),
        .wb        (chk_wb),
        .eff_size  (chk_size)
    );

    ldst_pair_steer #(.REG_AW(REG_AW)) u_pair (
        .rt_idx   (rt_idx),
        .le_mode  (le_mode),
        .prefixed (prefixed),
        .lo_idx   (pr_lo),
        .hi_idx   (pr_hi)
    );

    assign in_ready = !rst;
    assign accept   = in_valid && in_ready;

    always_comb begin
        nxt.addr   = ea;
        nxt.size   = chk_size;
        nxt.write  = is_store;
        nxt.bad    = chk_bad;
        nxt.wb     = chk_wb;
        nxt.wb_idx = ra_idx;
        nxt.lo_idx = pr_lo;
        nxt.hi_idx = pr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= accept;
            if (accept) begin
                res_q <= nxt;
            end
        end
    end

    assign out_valid   = vld_q;
    assign mem_req     = vld_q && !res_q.bad;
    assign wb_en       = vld_q && res_q.wb;
    assign invalid     = vld_q && res_q.bad;
    assign mem_write   = res_q.write;
    assign mem_size    = res_q.size;
    assign mem_addr    = res_q.addr;
    assign wb_idx      = res_q.wb_idx;
    assign quad_lo_idx = res_q.lo_idx;
    assign quad_hi_idx = res_q.hi_idx;
endmodule

// File: rtl/ldst_agu_sva.sv
module ldst_agu_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [4:0] rt_idx,
    input logic       out_valid,
    input logic       mem_req,
    input logic       mem_write,
    input logic [2:0] mem_size,
    input logic       wb_en,
    input logic [4:0] wb_idx,
    input logic       invalid
);
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_valid);

    a_r7_gate: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (!mem_req && !wb_en));

    a_r4_base_nonzero: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != 5'd0));

    a_r5_load_self: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !mem_write) |-> (wb_idx != $past(rt_idx)));

    a_r8_quad_no_wb: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mem_size == 3'd7) |-> !wb_en);

    a_r6_wb_needs_req: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> mem_req);
endmodule

bind ldst_agu ldst_agu_sva u_ldst_agu_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .rt_idx    (rt_idx),
    .out_valid (out_valid),
    .mem_req   (mem_req),
    .mem_write (mem_write),
    .mem_size  (mem_size),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .invalid   (invalid)
);

// File: tb/ldst_agu_bench.sv
`timescale 1ns/1ps
module ldst_agu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  rt_idx = '0;
    logic [4:0]  ra_idx = '0;
    logic [63:0] base_val = '0;
    logic [63:0] rb_val = '0;
    logic [15:0] imm_val = '0;
    logic        disp_sel = 1'b0;
    logic        is_update = 1'b0;
    logic        is_store = 1'b0;
    logic [2:0]  size_code = '0;
    logic        is_quad = 1'b0;
    logic        le_mode = 1'b0;
    logic        prefixed = 1'b0;
    logic        out_valid, mem_req, mem_write, wb_en, invalid;
    logic [2:0]  mem_size;
    logic [63:0] mem_addr;
    logic [4:0]  wb_idx, quad_lo_idx, quad_hi_idx;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ldst_agu u_ldst_agu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .rt_idx(rt_idx), .ra_idx(ra_idx), .base_val(base_val), .rb_val(rb_val),
        .imm_val(imm_val), .disp_sel(disp_sel), .is_update(is_update),
        .is_store(is_store), .size_code(size_code), .is_quad(is_quad),
        .le_mode(le_mode), .prefixed(prefixed), .out_valid(out_valid),
        .mem_req(mem_req), .mem_write(mem_write), .mem_size(mem_size),
        .mem_addr(mem_addr), .wb_en(wb_en), .wb_idx(wb_idx), .invalid(invalid),
        .quad_lo_idx(quad_lo_idx), .quad_hi_idx(quad_hi_idx)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model: one operation per clock, expected values from the requirements.
    task automatic op(input bit v, input int rt, input int ra, input logic [63:0] base,
                      input logic [63:0] rb, input logic [15:0] imm, input bit sel,
                      input bit upd, input bit st, input int sz, input bit quad,
                      input bit le, input bit pf);
        logic [63:0] disp, ea;
        bit bad, wb;
        int lo, hi, esz;
        in_valid = v; rt_idx = 5'(rt); ra_idx = 5'(ra); base_val = base; rb_val = rb;
        imm_val = imm; disp_sel = sel; is_update = upd; is_store = st;
        size_code = 3'(sz); is_quad = quad; le_mode = le; prefixed = pf;
        disp = sel ? rb : {{48{imm[15]}}, imm};
        ea = (ra == 0) ? disp : base + disp;
        bad = 0;
        if (!quad && upd && ra == 0) bad = 1;
        if (!quad && upd && !st && ra == rt) bad = 1;
        if (quad && !st && ra == rt) bad = 1;
        if (!quad && sz >= 6) bad = 1;
        wb = upd && !quad && !bad;
        if (le && pf) begin lo = rt; hi = (rt + 1) % 32; end
        else begin lo = (rt + 1) % 32; hi = rt; end
        esz = quad ? 7 : sz;
        @(negedge clk);
        chk("R2", "out_valid", 64'(out_valid), 64'(v));
        if (v) begin
            chk("R7", "invalid", 64'(invalid), 64'(bad));
            chk("R7", "mem_req", 64'(mem_req), 64'(!bad));
            chk("R6", "wb_en", 64'(wb_en), 64'(wb));
            if (!bad) begin
                chk("R3", "mem_addr", mem_addr, ea);
                chk("R10", "mem_write", 64'(mem_write), 64'(st));
                chk("R10", "mem_size", 64'(mem_size), 64'(esz));
            end
            if (wb) chk("R6", "wb_idx", 64'(wb_idx), 64'(ra));
            if (quad) begin
                chk("R9", "quad_lo_idx", 64'(quad_lo_idx), 64'(lo));
                chk("R9", "quad_hi_idx", 64'(quad_hi_idx), 64'(hi));
            end
        end else begin
            chk("R2", "mem_req idle", 64'(mem_req), 64'd0);
            chk("R2", "wb_en idle", 64'(wb_en), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        chk("R1", "mem_req in reset", 64'(mem_req), 64'd0);
        chk("R1", "wb_en in reset", 64'(wb_en), 64'd0);
        chk("R1", "invalid in reset", 64'(invalid), 64'd0);
        chk("R2", "in_ready in reset", 64'(in_ready), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk("R2", "in_ready", 64'(in_ready), 64'd1);

        // R3 address forms and R10 sizes
        op(1, 3, 4, 64'h1000, 0, 16'h0010, 0, 0, 0, 0, 0, 0, 0);
        op(1, 3, 4, 64'h1000, 0, 16'hFFF0, 0, 0, 0, 2, 0, 0, 0);
        op(1, 3, 0, 64'h1000, 0, 16'h8000, 0, 0, 1, 4, 0, 0, 0);
        op(1, 3, 5, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 0, 1, 0, 0, 5, 0, 0, 0);
        op(1, 3, 0, 64'h1234, 64'h55, 0, 1, 0, 1, 1, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R4 update with base zero
        op(1, 7, 0, 64'h40, 0, 16'h8, 0, 1, 1, 3, 0, 0, 0);
        // R5 update load self, then legal update store self (R6)
        op(1, 9, 9, 64'h40, 0, 16'h8, 0, 1, 0, 3, 0, 0, 0);
        op(1, 9, 9, 64'h40, 0, 16'h8, 0, 1, 1, 3, 0, 0, 0);
        op(1, 2, 6, 64'h800, 64'h10, 0, 1, 1, 0, 5, 0, 0, 0);
        // R11 reserved sizes
        op(1, 2, 6, 64'h800, 0, 16'h4, 0, 0, 0, 6, 0, 0, 0);
        op(1, 2, 6, 64'h800, 0, 16'h4, 0, 0, 1, 7, 0, 0, 0);
        // R8 / R9 quad
        op(1, 10, 10, 64'h100, 0, 16'h0, 0, 0, 0, 0, 1, 0, 0);
        op(1, 10, 10, 64'h100, 0, 16'h0, 0, 0, 1, 0, 1, 1, 1);
        op(1, 31, 4, 64'h200, 0, 16'h10, 0, 1, 0, 0, 1, 1, 1);
        op(1, 12, 4, 64'h200, 0, 16'h10, 0, 0, 0, 0, 1, 1, 0);
        op(1, 12, 4, 64'h200, 0, 16'h10, 0, 0, 1, 0, 1, 0, 1);
        op(1, 31, 4, 64'h200, 0, 16'h10, 0, 0, 1, 0, 1, 0, 0);
        // legal right after invalid, back to back
        op(1, 5, 0, 64'h0, 0, 16'h4, 0, 1, 0, 1, 0, 0, 0);
        op(1, 5, 6, 64'h300, 0, 16'h4, 0, 1, 0, 1, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            op(1, (i * 7) % 32, (i * 3) % 32, 64'(i) * 64'h1111_0000_0001, 64'(i * 13),
               16'(i * 977), i[0], i[1], i[2], i % 8, (i % 5) == 0, i[3], i[2]);
        end
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule